// File: doc/BRIEF.md
# Power-of-Two Output Divider Pair

This block takes a fast oscillator clock and derives two related clocks from it. The primary clock runs at the input rate divided by 1, 2, 4 or 8, chosen by a 2-bit select code. The companion clock always runs at half the primary rate. Each clock leaves the block as a true signal and its inverted twin, and both keep a 50% duty cycle.

Every divided output is one bit of a single free-running 4-bit counter, so all outputs share one time base. For divide-by-1, the primary output is the input clock itself, gated by reset. The select code is captured only when the counter wraps from all ones to zero. At that moment every counter bit falls together, so a new ratio can never cut a pulse short.

An active-high master reset clears the counter and forces the true outputs low and the inverted outputs high. When reset is released the counter restarts from zero with the code that was present during reset.

Top module: `odiv_pair`

## Requirements
- R1: While `mreset` is high, `prim_p` and `half_p` are 0 and `prim_n` and `half_n` are 1, in both clock phases.
- R2: The divide ratio of the primary output follows `div_code`: 0 divides by 1, 1 by 2, 2 by 4, 3 by 8.
- R3: The period of the half-rate output is exactly twice that of the primary output. For codes 1 to 3, `half_p` changes on exactly the edges where `prim_p` falls.
- R4: Both true outputs have a 50% duty cycle. For a ratio N of at least 2, the primary output is low for N/2 input cycles and then high for N/2 input cycles. For N=1 it equals the input clock.
- R5: After reset is released, the k-th rising input edge sets the primary output (code c ≥ 1) to bit c-1 of (k mod 16) and the half output to bit c of (k mod 16). For code 0 the half output is bit 0 of (k mod 16).
- R6: A change of `div_code` takes effect only at the rising edge where the 16-cycle frame counter wraps from 15 to 0. At all other edges the previously captured code stays in force.
- R7: `prim_n` and `half_n` are the logical complements of `prim_p` and `half_p` at all times.
- R8: The code present at the last rising edge during reset is in force from the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast clock to be divided |
| mreset | input | 1 | Active-high master reset |
| div_code | input | 2 | Primary divide select: 0→1, 1→2, 2→4, 3→8 |
| prim_p | output | 1 | Primary divided clock, true |
| prim_n | output | 1 | Primary divided clock, inverted |
| half_p | output | 1 | Half-rate clock, true |
| half_n | output | 1 | Half-rate clock, inverted |

## Verification
The embedded assertions check on every cycle the following properties:
- reset clears the counter;
- the counter advances by one per edge;
- the captured code moves only at the frame wrap;
- for ratios of 2 and above, the half-rate output changes exactly when the primary output falls.

Only the bench scenarios can show the rest:
- the absolute ratio for each code, including the ungated input clock for divide-by-1;
- the output levels in both clock phases;
- the complementary pairs;
- that a code change in mid-frame is held back until the wrap, which the bench shows for every pair of old and new codes.

// File: rtl/odiv_pkg.sv
package odiv_pkg;
    // Width of the free-running frame counter for a given code width:
    // a code of CODE_W bits selects ratios up to 2**(2**CODE_W - 1),
    // and the half-rate output needs one more counter bit.
    function automatic int frame_width(input int code_w);
        return 1 << code_w;
    endfunction
endpackage

// File: rtl/odiv_frame_ctr.sv
module odiv_frame_ctr #(
    parameter int CODE_W = 2,
    localparam int CNT_W = odiv_pkg::frame_width(CODE_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CODE_W-1:0] sel_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] sel;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.cnt = '0;
            st_d.sel = code_i;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (&st_q.cnt) begin
                st_d.sel = code_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign sel_o = st_q.sel;

    // R1: reset leaves the counter cleared
    a_r1_reset_clear: assert property (@(posedge clk_i)
        rst_i |=> (cnt_o == '0));

    // R5: counter advances by one on every running edge
    a_r5_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R6: captured code moves only at the frame wrap
    a_r6_sel_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(&cnt_o) |=> $stable(sel_o));
endmodule

// File: rtl/odiv_tap_mux.sv
module odiv_tap_mux #(
    parameter int CODE_W = 2,
    parameter int OFFSET = 0,
    localparam int CNT_W = odiv_pkg::frame_width(CODE_W),
    localparam int IDX_W = CODE_W + 1
) (
    input  logic              clk_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic              tap_o
);
    // Tap 0 is the undivided clock, tap i+1 is counter bit i.
    logic [CNT_W:0] taps;
    logic [IDX_W-1:0] idx;

    assign taps[0] = clk_i;
    for (genvar i = 0; i < CNT_W; i++) begin : g_tap
        assign taps[i+1] = cnt_i[i];
    end

    assign idx   = {1'b0, sel_i} + IDX_W'(OFFSET);
    assign tap_o = taps[idx];
endmodule

// File: rtl/odiv_out_pair.sv
module odiv_out_pair (
    input  logic rst_i,
    input  logic tap_i,
    output logic true_o,
    output logic inv_o
);
    always_comb begin
        true_o = tap_i & ~rst_i;
        inv_o  = ~true_o;
    end
endmodule

// File: rtl/odiv_pair.sv
module odiv_pair #(
    parameter int CODE_W = 2,
    localparam int CNT_W = odiv_pkg::frame_width(CODE_W)
) (
    input  logic              vco_clk,
    input  logic              mreset,
    input  logic [CODE_W-1:0] div_code,
    output logic              prim_p,
    output logic              prim_n,
    output logic              half_p,
    output logic              half_n
);
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] sel;
    logic [1:0]        tap;
    logic [1:0]        out_t;
    logic [1:0]        out_i;

    odiv_frame_ctr #(.CODE_W(CODE_W)) u_ctr (
        .clk_i (vco_clk),
        .rst_i (mreset),
        .code_i(div_code),
        .cnt_o (cnt),
        .sel_o (sel)
    );

    // Output 0 is primary, output 1 is half-rate (one tap further up).
    for (genvar g = 0; g < 2; g++) begin : g_out
        odiv_tap_mux #(.CODE_W(CODE_W), .OFFSET(g)) u_mux (
            .clk_i(vco_clk),
            .cnt_i(cnt),
            .sel_i(sel),
            .tap_o(tap[g])
        );
        odiv_out_pair u_drv (
            .rst_i (mreset),
            .tap_i (tap[g]),
            .true_o(out_t[g]),
            .inv_o (out_i[g])
        );
    end

    assign prim_p = out_t[0];
    assign prim_n = out_i[0];
    assign half_p = out_t[1];
    assign half_n = out_i[1];

    // R3: for ratios of 2 and up, the half output toggles exactly when the primary falls
    a_r3_half_follows: assert property (@(posedge vco_clk) disable iff (mreset)
        (sel != '0 && sel == $past(sel)) |-> ($fell(prim_p) == !$stable(half_p)));
endmodule

// File: tb/tb_odiv_pair.sv
module tb_odiv_pair;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] code = 2'd0;
    logic       prim_p, prim_n, half_p, half_n;

    int total = 0;
    int bad   = 0;
    int k     = 0;
    int sel_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    odiv_pair dut (
        .vco_clk (clk),
        .mreset  (rst),
        .div_code(code),
        .prim_p  (prim_p),
        .prim_n  (prim_n),
        .half_p  (half_p),
        .half_n  (half_n)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s k=%0d sel=%0d act=%0b exp=%0b", tag, what, k, sel_m, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input bit phase_high);
        logic [3:0] cb;
        logic ep, eh;
        cb = 4'(k % 16);
        ep = (sel_m == 0) ? phase_high : cb[sel_m-1];
        eh = cb[sel_m];
        check(tag, "prim_p", prim_p, ep);
        check(tag, "half_p", half_p, eh);
        check("R7", "prim_n", prim_n, ~ep);
        check("R7", "half_n", half_n, ~eh);
    endtask

    task automatic run_cycles(input string tag, input int n);
        repeat (n) begin
            @(posedge clk);
            if (k % 16 == 15) sel_m = code;
            k++;
            #1 check_all(tag, 1'b1);
            @(negedge clk);
            #1 check_all(tag, 1'b0);
        end
    endtask

    task automatic check_reset_levels();
        check("R1", "prim_p", prim_p, 1'b0);
        check("R1", "prim_n", prim_n, 1'b1);
        check("R1", "half_p", half_p, 1'b0);
        check("R1", "half_n", half_n, 1'b1);
    endtask

    task automatic do_reset(input int c);
        @(negedge clk);
        rst  = 1'b1;
        code = 2'(c);
        #1 check_reset_levels();
        repeat (3) begin
            @(posedge clk);
            #1 check_reset_levels();
            @(negedge clk);
            #1 check_reset_levels();
        end
        rst   = 1'b0;
        k     = 0;
        sel_m = c;
        #1 check_all("R8", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Reset state from time zero (R1)
        #1 check_reset_levels();

        // Every ratio from a fresh reset, two full frames each (R2 R3 R4 R5 R8)
        for (int c = 0; c < 4; c++) begin
            do_reset(c);
            run_cycles("R2 R3 R4 R5", 40);
        end

        // Mid-frame code changes for every old/new pair (R6)
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset(a);
                run_cycles("R6", 3 + a);
                code = 2'(b);
                run_cycles("R6", 36);
            end
        end

        // Reset asserted while running, then restart (R1)
        do_reset(3);
        run_cycles("R5", 11);
        do_reset(1);
        run_cycles("R1", 20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule